// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind a bit-level I2C receiver and decides, byte by byte, whether the device has been addressed. The receiver marks each START or repeated START on `start_i` and each completed byte on `byte_vld_i`. Only the first byte after a start marker is treated as an address header. That byte is compared with the own-address setting in either the 7-bit or the 10-bit format. It is also tested for the all-zero broadcast address. The results are held on two flags, and a one-cycle interrupt pulse accompanies every hit.

In 10-bit mode the header byte is compared in full, including its direction bit. The expected direction bit is the OR of a software-driven input and an internal bit. With the low-byte compare enabled, the hardware sets the internal bit itself when the second address byte equals `own_lo_i`. The header that is sent again with R/W = 1 after a repeated START then matches without software involvement. A STOP or dropping the enable returns the block to idle.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode (`mode_10b_i` = 0), a header byte whose bits [7:1] equal `own_addr_i` sets `slave_sel_o`. Bit 0 (R/W) plays no part in the compare.
- R2: In 10-bit mode (`mode_10b_i` = 1), a header byte matches only if it equals {`own_addr_i`, expected R/W}. The expected R/W is `dir_match_i` OR the internally set direction bit.
- R3: A header byte of 8'h00 sets `gen_call_o` and clears `slave_sel_o` in both modes. This holds even when the own address would also match.
- R4: A header byte that is neither a match nor 8'h00 clears both flags and raises no interrupt.
- R5: `irq_o` is high for exactly the one clock after the strobe of a header that matched or was a general call. The flags take their new values on that same edge.
- R6: Only the first strobed byte after `start_i` is evaluated. Later bytes leave both flags unchanged. A byte strobed in the same cycle as `start_i` is discarded.
- R7: With `lo_cmp_en_i` = 1, the byte after a matching 10-bit header is compared with `own_lo_i`. If equal, the internal direction bit is set, so a header with R/W = 1 matches after the next start. A mismatch, or `lo_cmp_en_i` = 0, leaves that bit clear.
- R8: `stop_i` = 1 or `en_i` = 0 clears both flags, the internal direction bit and all pending header state on the next edge. No byte is evaluated again until a new `start_i`.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Recognizer enable; low clears state |
| mode_10b_i | input | 1 | 0: 7-bit format, 1: 10-bit format |
| own_addr_i | input | 7 | Own address (7-bit) or 10-bit header bits |
| dir_match_i | input | 1 | Software-set expected R/W for 10-bit headers |
| lo_cmp_en_i | input | 1 | Enables hardware compare of the second 10-bit byte |
| own_lo_i | input | 8 | Low eight bits of the 10-bit address |
| start_i | input | 1 | START or repeated START seen |
| stop_i | input | 1 | STOP seen |
| byte_i | input | 8 | Received byte, MSB first on the wire |
| byte_vld_i | input | 1 | One-cycle strobe: `byte_i` is complete |
| slave_sel_o | output | 1 | Device addressed as slave |
| gen_call_o | output | 1 | General call received |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Every result is registered once. Flags and the interrupt pulse are due on the first edge after the strobe, and the second edge must show the interrupt low with the flags unchanged. Start, stop and enable effects are likewise due one edge after they are driven. Each stimulus task queues the expected output triple together with the cycle number it is due in. The monitor pops and compares only on the falling edge of that cycle. Drivers leave an idle cycle after every byte, so the second-cycle check of one stimulus cannot overlap the next stimulus.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef struct packed {
    logic hit;
    logic gc;
  } am_eval_t;
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              mode_10b_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              exp_rw_i,
  input  logic [BYTE_W-1:0] own_lo_i,
  output am_eval_t          eval_o,
  output logic              lo_hit_o
);
  logic hit7, hit10;

  assign hit7      = (byte_i[BYTE_W-1:1] == own_addr_i);
  // 10-bit header: direction bit is part of the address
  assign hit10     = (byte_i == {own_addr_i, exp_rw_i});
  assign eval_o.gc = (byte_i == '0);
  assign eval_o.hit = mode_10b_i ? hit10 : hit7;
  assign lo_hit_o  = (byte_i == own_lo_i);
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     mode_10b_i,
  input  logic     lo_cmp_en_i,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     byte_vld_i,
  input  am_eval_t eval_i,
  input  logic     lo_hit_i,
  output logic     rw_auto_o,
  output logic     slave_sel_o,
  output logic     gen_call_o,
  output logic     irq_o
);
  logic hdr_q, lo_pend_q, rw_auto_q, sel_q, gc_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q     <= 1'b0;
      lo_pend_q <= 1'b0;
      rw_auto_q <= 1'b0;
      sel_q     <= 1'b0;
      gc_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i || !en_i) begin
        hdr_q     <= 1'b0;
        lo_pend_q <= 1'b0;
        rw_auto_q <= 1'b0;
        sel_q     <= 1'b0;
        gc_q      <= 1'b0;
      end else if (start_i) begin
        // start wins over a coincident byte strobe
        hdr_q     <= 1'b1;
        lo_pend_q <= 1'b0;
      end else if (byte_vld_i) begin
        if (hdr_q) begin
          hdr_q     <= 1'b0;
          gc_q      <= eval_i.gc;
          sel_q     <= eval_i.hit && !eval_i.gc;
          irq_q     <= eval_i.hit || eval_i.gc;
          lo_pend_q <= mode_10b_i && lo_cmp_en_i && eval_i.hit && !eval_i.gc;
        end else if (lo_pend_q) begin
          lo_pend_q <= 1'b0;
          if (lo_hit_i) rw_auto_q <= 1'b1;
        end
      end
    end
  end

  assign rw_auto_o   = rw_auto_q;
  assign slave_sel_o = sel_q;
  assign gen_call_o  = gc_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_10b_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              dir_match_i,
  input  logic              lo_cmp_en_i,
  input  logic [BYTE_W-1:0] own_lo_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic              slave_sel_o,
  output logic              gen_call_o,
  output logic              irq_o
);
  am_eval_t eval;
  logic     lo_hit, rw_auto, exp_rw;

  assign exp_rw = dir_match_i | rw_auto;

  i2c_am_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_i     (byte_i),
    .mode_10b_i (mode_10b_i),
    .own_addr_i (own_addr_i),
    .exp_rw_i   (exp_rw),
    .own_lo_i   (own_lo_i),
    .eval_o     (eval),
    .lo_hit_o   (lo_hit)
  );

  i2c_am_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_10b_i  (mode_10b_i),
    .lo_cmp_en_i (lo_cmp_en_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .byte_vld_i  (byte_vld_i),
    .eval_i      (eval),
    .lo_hit_i    (lo_hit),
    .rw_auto_o   (rw_auto),
    .slave_sel_o (slave_sel_o),
    .gen_call_o  (gen_call_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic stop_i,
  input logic byte_vld_i,
  input logic slave_sel_o,
  input logic gen_call_o,
  input logic irq_o
);
  a_r3_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slave_sel_o && gen_call_o));

  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r5_irq_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(byte_vld_i));

  a_r5_irq_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (slave_sel_o || gen_call_o));

  a_r6_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && !stop_i && en_i) |=> ($stable(slave_sel_o) && $stable(gen_call_o)));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || !en_i) |=> (!slave_sel_o && !gen_call_o && !irq_o));

  always_comb begin
    if (!rst_ni) begin
      a_r9_reset_outputs: assert (!slave_sel_o && !gen_call_o && !irq_o);
    end
  end
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .stop_i      (stop_i),
  .byte_vld_i  (byte_vld_i),
  .slave_sel_o (slave_sel_o),
  .gen_call_o  (gen_call_o),
  .irq_o       (irq_o)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       mode_10b_i = 1'b0;
  logic [6:0] own_addr_i = 7'h2A;
  logic       dir_match_i = 1'b0;
  logic       lo_cmp_en_i = 1'b0;
  logic [7:0] own_lo_i = 8'h5C;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_vld_i = 1'b0;
  logic       slave_sel_o, gen_call_o, irq_o;

  always #10 clk_i = ~clk_i;

  i2c_addr_match u_dut (.*);

  typedef struct {
    int    due;
    bit    irq;
    bit    sel;
    bit    gc;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   m_sel = 0, m_gc = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if ({irq_o, slave_sel_o, gen_call_o} !== {it.irq, it.sel, it.gc}) begin
        errors++;
        $display("FAIL %s cyc %0d: irq/sel/gc actual %b%b%b expected %b%b%b",
                 it.tag, cyc, irq_o, slave_sel_o, gen_call_o, it.irq, it.sel, it.gc);
      end
    end
  end

  task automatic push(int due, bit irq, bit sel, bit gc, string tag);
    exp_t e;
    e.due = due; e.irq = irq; e.sel = sel; e.gc = gc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send(logic [7:0] b, bit irq, bit sel, bit gc, string tag);
    byte_i = b;
    byte_vld_i = 1'b1;
    push(cyc + 1, irq, sel, gc, tag);
    push(cyc + 2, 1'b0, sel, gc, tag);
    m_sel = sel; m_gc = gc;
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_start(string tag);
    start_i = 1'b1;
    push(cyc + 1, 1'b0, m_sel, m_gc, tag);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic do_stop(string tag);
    stop_i = 1'b1;
    push(cyc + 1, 1'b0, 1'b0, 1'b0, tag);
    m_sel = 0; m_gc = 0;
    @(negedge clk_i);
    stop_i = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    checks++;
    if ({irq_o, slave_sel_o, gen_call_o} !== 3'b000) begin
      errors++;
      $display("FAIL R9 reset actual %b%b%b expected 000", irq_o, slave_sel_o, gen_call_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: 7-bit match, R/W ignored
    do_start("R1");
    send(8'h54, 1, 1, 0, "R1 match rw0");
    do_start("R1");
    send(8'h55, 1, 1, 0, "R1 match rw1");
    // R4: no match clears
    do_start("R4");
    send(8'h56, 0, 0, 0, "R4 mismatch");
    // R3: general call in 7-bit mode
    do_start("R3");
    send(8'h00, 1, 0, 1, "R3 gc 7b");
    // R6: data byte without start ignored
    send(8'h54, 0, 0, 1, "R6 data byte");
    // R8: stop clears
    do_stop("R8 stop");
    // R6: start with coincident byte, byte discarded
    start_i = 1'b1; byte_i = 8'h54; byte_vld_i = 1'b1;
    push(cyc + 1, 0, 0, 0, "R6 start+byte");
    @(negedge clk_i);
    start_i = 1'b0; byte_vld_i = 1'b0;
    send(8'h56, 0, 0, 0, "R6 first after start");
    // R3: gc wins over own address 0
    own_addr_i = 7'h00;
    do_start("R3");
    send(8'h00, 1, 0, 1, "R3 gc over match");
    own_addr_i = 7'h7A;
    do_stop("R8");

    // R2: 10-bit header, R/W compared
    mode_10b_i = 1'b1;
    do_start("R2");
    send(8'hF4, 1, 1, 0, "R2 hdr rw0");
    do_start("R2");
    send(8'hF5, 0, 0, 0, "R2 hdr rw1 mismatch");
    do_start("R3");
    send(8'h00, 1, 0, 1, "R3 gc 10b");
    do_stop("R8");

    // R7: hardware low-byte compare
    lo_cmp_en_i = 1'b1;
    do_start("R7");
    send(8'hF4, 1, 1, 0, "R7 hdr");
    send(8'h5C, 0, 1, 0, "R7 low byte");
    do_start("R7");
    send(8'hF5, 1, 1, 0, "R7 read hdr matches");
    // R8: stop clears the auto direction bit
    do_stop("R8");
    do_start("R8");
    send(8'hF5, 0, 0, 0, "R8 auto bit cleared");
    // R7: low-byte mismatch
    do_start("R7");
    send(8'hF4, 1, 1, 0, "R7 hdr");
    send(8'h11, 0, 1, 0, "R7 low mismatch");
    do_start("R7");
    send(8'hF5, 0, 0, 0, "R7 no auto on mismatch");
    // R7: compare disabled
    lo_cmp_en_i = 1'b0;
    do_start("R7");
    send(8'hF4, 1, 1, 0, "R7 hdr");
    send(8'h5C, 0, 1, 0, "R7 low byte disabled");
    do_start("R7");
    send(8'hF5, 0, 0, 0, "R7 disabled no auto");
    // R2: software direction bit
    do_stop("R8");
    dir_match_i = 1'b1;
    do_start("R2");
    send(8'hF5, 1, 1, 0, "R2 sw dir");
    // R8: enable low clears, later bytes ignored until start
    en_i = 1'b0;
    push(cyc + 1, 0, 0, 0, "R8 disable");
    m_sel = 0; m_gc = 0;
    @(negedge clk_i);
    en_i = 1'b1;
    send(8'hF5, 0, 0, 0, "R8 no eval without start");

    repeat (4) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL monitor: %0d items unchecked, expected 0", exp_q.size());
    end
    summary();
  end
endmodule